// File: doc/BRIEF.md
# TDD Interrupt and Status Generator

This block turns the timing events of a time-division-duplex radio frame into a single active-low interrupt for the host CPU, plus a status byte the CPU reads to learn why it was interrupted. A frame holds a transmit half and a receive half. Each half is a preamble slot, an ID/status slot and four payload subframes. The event sources report the end of each transmit or receive subframe, the end of each half-frame, CRC errors, frame errors and detection of a matching user ID.

The kind of timing event is not given one flag each. It is encoded jointly in three status bits: transmit-done, receive-done and subframe. A write-only control byte holds the interrupt enables and two mode bits that are passed on to the rest of the chip. Subframe interrupts need both the subframe enable and the enable for their direction. A half-frame-end interrupt needs only the direction enable.

The block also drives two active-low pins, one for CRC error and one for ID detected. It reflects the two link-lock states and samples the antenna-switch pin at each subframe boundary. Reading the status byte acknowledges the interrupt.

Top module: `tdd_irq_status`

## Requirements
- R1: After reset the status byte is 0x00, intr_no, cer_no and id_det_no are 1, and master_o and test_mode_o are 0.
- R2: A transmit subframe end while control bits SUBE (bit 4) and TE (bit 3) are both 1 loads TND (bit 1)=1, RND (bit 0)=0, SUBF (bit 4)=1 and drives intr_no low on the following cycle.
- R3: A receive subframe end while SUBE and RE (bit 2) are both 1 loads TND=0, RND=1, SUBF=1 and drives intr_no low.
- R4: A transmit frame end while TE is 1 loads TND=1, RND=0, SUBF=0; a receive frame end while RE is 1 loads TND=0, RND=1, SUBF=0; each drives intr_no low.
- R5: A timing event whose enables are not all set changes none of TND, RND, SUBF and leaves intr_no unchanged.
- R6: A frame error always sets FER (bit 3). It drives intr_no low only when RE is 1.
- R7: A CRC error sets CER (bit 2), and cer_no is the inverse of CER.
- R8: A status read (stat_rd_i) clears SUBF, FER, CER, TND and RND and releases intr_no. It leaves LK (bit 7), RLK (bit 6) and ADIR (bit 5) unchanged.
- R9: An event in the same cycle as a status read wins: its flags and interrupt are set after that edge.
- R10: At each receive frame end, id_det_no goes low if uid_det_i was pulsed since the previous receive frame end (including that cycle), else high, and holds until the next receive frame end.
- R11: On any of the four timing events, enabled or not, ADIR takes the value of ant_sw_i in that cycle.
- R12: LK and RLK follow lock_i and rlock_i after SYNC_STAGES clock edges (default 1).
- R13: A control write stores bits 4:0. master_o shows bit 1 and test_mode_o shows bit 0. Bits 7:5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte write data |
| stat_rd_i | input | 1 | Status byte read strobe (clears event flags) |
| tx_sub_end_i | input | 1 | Transmit subframe ended |
| rx_sub_end_i | input | 1 | Receive subframe ended |
| tx_frame_end_i | input | 1 | Transmit half-frame ended |
| rx_frame_end_i | input | 1 | Receive half-frame ended |
| crc_err_i | input | 1 | CRC error detected |
| frame_err_i | input | 1 | Frame error detected |
| uid_det_i | input | 1 | Matching user ID detected |
| lock_i | input | 1 | Local link lock state |
| rlock_i | input | 1 | Remote link lock state |
| ant_sw_i | input | 1 | Antenna switch pin level |
| status_o | output | 8 | Status byte {LK,RLK,ADIR,SUBF,FER,CER,TND,RND} |
| intr_no | output | 1 | CPU interrupt, active low |
| cer_no | output | 1 | CRC error pin, active low |
| id_det_no | output | 1 | ID detected in prior frame, active low |
| master_o | output | 1 | Master/slave mode bit |
| test_mode_o | output | 1 | Test/normal mode bit |

## Verification
The assertions assume that at most one of the four timing events is pulsed in any cycle, because a single subframe boundary cannot be both transmit and receive. Frame errors, CRC errors, ID detections and status reads may coincide with any of them. The stimulus draws at most one timing event per cycle. It pairs the other inputs freely with that event, including reads landing on event cycles and control writes landing on event cycles.

// File: rtl/tdd_irq_pkg.sv
package tdd_irq_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned CTRL_W = 5;

  localparam int unsigned ST_LK   = 7;
  localparam int unsigned ST_RLK  = 6;
  localparam int unsigned ST_ADIR = 5;
  localparam int unsigned ST_SUBF = 4;
  localparam int unsigned ST_FER  = 3;
  localparam int unsigned ST_CER  = 2;
  localparam int unsigned ST_TND  = 1;
  localparam int unsigned ST_RND  = 0;

  typedef struct packed {
    logic sub_en;
    logic tx_en;
    logic rx_en;
    logic master;
    logic test;
  } ctrl_t;

  // {subf, tnd, rnd}
  typedef enum logic [2:0] {
    EV_NONE   = 3'b000,
    EV_TX_SUB = 3'b110,
    EV_RX_SUB = 3'b101,
    EV_TX_END = 3'b010,
    EV_RX_END = 3'b001
  } ev_code_e;
endpackage

// File: rtl/tdd_irq_ctrl_reg.sv
module tdd_irq_ctrl_reg
  import tdd_irq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [STAT_W-1:0] wdata_i,
  output ctrl_t       ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_o <= '0;
    else if (we_i) ctrl_o <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  p_write_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (ctrl_o == ctrl_t'($past(wdata_i[CTRL_W-1:0]))));
endmodule

// File: rtl/tdd_irq_flags.sv
module tdd_irq_flags
  import tdd_irq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ctrl_t ctrl_i,
  input  logic  rd_i,
  input  logic  tx_sub_i,
  input  logic  rx_sub_i,
  input  logic  tx_end_i,
  input  logic  rx_end_i,
  input  logic  crc_i,
  input  logic  ferr_i,
  output logic  subf_o,
  output logic  tnd_o,
  output logic  rnd_o,
  output logic  fer_o,
  output logic  cer_o,
  output logic  pend_o
);
  ev_code_e code;
  logic     load;
  logic     irq;

  always_comb begin
    code = EV_NONE;
    load = 1'b0;
    if (tx_sub_i && ctrl_i.sub_en && ctrl_i.tx_en) begin
      code = EV_TX_SUB; load = 1'b1;
    end else if (rx_sub_i && ctrl_i.sub_en && ctrl_i.rx_en) begin
      code = EV_RX_SUB; load = 1'b1;
    end else if (tx_end_i && ctrl_i.tx_en) begin
      code = EV_TX_END; load = 1'b1;
    end else if (rx_end_i && ctrl_i.rx_en) begin
      code = EV_RX_END; load = 1'b1;
    end
    irq = load || (ferr_i && ctrl_i.rx_en);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {subf_o, tnd_o, rnd_o} <= EV_NONE;
      fer_o  <= 1'b0;
      cer_o  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      if (load)      {subf_o, tnd_o, rnd_o} <= code;
      else if (rd_i) {subf_o, tnd_o, rnd_o} <= EV_NONE;
      if (ferr_i)    fer_o <= 1'b1;
      else if (rd_i) fer_o <= 1'b0;
      if (crc_i)     cer_o <= 1'b1;
      else if (rd_i) cer_o <= 1'b0;
      if (irq)       pend_o <= 1'b1;
      else if (rd_i) pend_o <= 1'b0;
    end
  end

  p_one_event_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_sub_i, rx_sub_i, tx_end_i, rx_end_i}));
  p_tx_sub_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_sub_i && ctrl_i.sub_en && ctrl_i.tx_en) |=> (subf_o && tnd_o && !rnd_o && pend_o));
  p_rx_sub_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_sub_i && ctrl_i.sub_en && ctrl_i.rx_en) |=> (subf_o && !tnd_o && rnd_o && pend_o));
  p_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_sub_i && !(ctrl_i.sub_en && ctrl_i.tx_en) && !rd_i && !ferr_i)
      |=> ($stable({subf_o, tnd_o, rnd_o}) && $stable(pend_o)));
  p_fer_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_i |=> fer_o);
  p_read_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !tx_sub_i && !rx_sub_i && !tx_end_i && !rx_end_i && !crc_i && !ferr_i)
      |=> (!subf_o && !tnd_o && !rnd_o && !fer_o && !cer_o && !pend_o));
  p_event_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && crc_i) |=> cer_o);
endmodule

// File: rtl/tdd_irq_pins.sv
module tdd_irq_pins #(
  parameter int unsigned SYNC_STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_ev_i,
  input  logic rx_end_i,
  input  logic uid_det_i,
  input  logic ant_sw_i,
  input  logic lock_i,
  input  logic rlock_i,
  output logic lk_o,
  output logic rlk_o,
  output logic adir_o,
  output logic id_det_o
);
  localparam int unsigned NS = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  logic [1:0] sync_q [NS];
  logic       uid_seen_q;

  for (genvar g = 0; g < NS; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 2'b00;
      else         sync_q[g] <= (g == 0) ? {lock_i, rlock_i} : sync_q[(g == 0) ? 0 : g-1];
    end
  end
  assign {lk_o, rlk_o} = sync_q[NS-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adir_o     <= 1'b0;
      uid_seen_q <= 1'b0;
      id_det_o   <= 1'b0;
    end else begin
      if (any_ev_i) adir_o <= ant_sw_i;
      if (rx_end_i) begin
        id_det_o   <= uid_seen_q | uid_det_i;
        uid_seen_q <= 1'b0;
      end else if (uid_det_i) begin
        uid_seen_q <= 1'b1;
      end
    end
  end

  p_id_det_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_end_i && uid_det_i) |=> id_det_o);
  p_id_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_end_i |=> $stable(id_det_o));
  p_adir_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_ev_i |=> (adir_o == $past(ant_sw_i)));
endmodule

// File: rtl/tdd_irq_status.sv
module tdd_irq_status
  import tdd_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [STAT_W-1:0] ctrl_wdata_i,
  input  logic              stat_rd_i,
  input  logic              tx_sub_end_i,
  input  logic              rx_sub_end_i,
  input  logic              tx_frame_end_i,
  input  logic              rx_frame_end_i,
  input  logic              crc_err_i,
  input  logic              frame_err_i,
  input  logic              uid_det_i,
  input  logic              lock_i,
  input  logic              rlock_i,
  input  logic              ant_sw_i,
  output logic [STAT_W-1:0] status_o,
  output logic              intr_no,
  output logic              cer_no,
  output logic              id_det_no,
  output logic              master_o,
  output logic              test_mode_o
);
  ctrl_t ctrl;
  logic  subf, tnd, rnd, fer, cer, pend;
  logic  lk, rlk, adir, id_det;
  logic  any_ev;

  assign any_ev = tx_sub_end_i | rx_sub_end_i | tx_frame_end_i | rx_frame_end_i;

  tdd_irq_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .ctrl_o  (ctrl)
  );

  tdd_irq_flags u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_i   (ctrl),
    .rd_i     (stat_rd_i),
    .tx_sub_i (tx_sub_end_i),
    .rx_sub_i (rx_sub_end_i),
    .tx_end_i (tx_frame_end_i),
    .rx_end_i (rx_frame_end_i),
    .crc_i    (crc_err_i),
    .ferr_i   (frame_err_i),
    .subf_o   (subf),
    .tnd_o    (tnd),
    .rnd_o    (rnd),
    .fer_o    (fer),
    .cer_o    (cer),
    .pend_o   (pend)
  );

  tdd_irq_pins #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .any_ev_i  (any_ev),
    .rx_end_i  (rx_frame_end_i),
    .uid_det_i (uid_det_i),
    .ant_sw_i  (ant_sw_i),
    .lock_i    (lock_i),
    .rlock_i   (rlock_i),
    .lk_o      (lk),
    .rlk_o     (rlk),
    .adir_o    (adir),
    .id_det_o  (id_det)
  );

  always_comb begin
    status_o          = '0;
    status_o[ST_LK]   = lk;
    status_o[ST_RLK]  = rlk;
    status_o[ST_ADIR] = adir;
    status_o[ST_SUBF] = subf;
    status_o[ST_FER]  = fer;
    status_o[ST_CER]  = cer;
    status_o[ST_TND]  = tnd;
    status_o[ST_RND]  = rnd;
  end

  assign intr_no     = ~pend;
  assign cer_no      = ~cer;
  assign id_det_no   = ~id_det;
  assign master_o    = ctrl.master;
  assign test_mode_o = ctrl.test;

  p_read_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !any_ev) |=> (status_o[ST_ADIR] == $past(status_o[ST_ADIR])));
  p_cer_pin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_i |=> !cer_no);
endmodule

// File: tb/tdd_irq_status_bench.sv
module tdd_irq_status_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LS = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 0, stat_rd = 0;
  logic [7:0] ctrl_wdata = 0;
  logic tx_sub = 0, rx_sub = 0, tx_end = 0, rx_end = 0;
  logic crc = 0, ferr = 0, uid = 0, lock = 0, rlock = 0, ant = 0;
  logic [7:0] status;
  logic intr_n, cer_n, iddet_n, master, tmode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdd_irq_status #(.SYNC_STAGES(LS)) u_tdd_irq_status (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .stat_rd_i(stat_rd), .tx_sub_end_i(tx_sub), .rx_sub_end_i(rx_sub),
    .tx_frame_end_i(tx_end), .rx_frame_end_i(rx_end), .crc_err_i(crc),
    .frame_err_i(ferr), .uid_det_i(uid), .lock_i(lock), .rlock_i(rlock),
    .ant_sw_i(ant), .status_o(status), .intr_no(intr_n), .cer_no(cer_n),
    .id_det_no(iddet_n), .master_o(master), .test_mode_o(tmode)
  );

  // behavioural reference
  bit m_sube, m_te, m_re, m_ms, m_tn;
  bit m_subf, m_tnd, m_rnd, m_fer, m_cer, m_pend, m_adir, m_seen, m_id, m_lk, m_rlk;
  bit lk_q[$];
  bit rlk_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_sube, m_te, m_re, m_ms, m_tn} = 0;
      {m_subf, m_tnd, m_rnd, m_fer, m_cer, m_pend, m_adir, m_seen, m_id, m_lk, m_rlk} = 0;
      lk_q.delete(); rlk_q.delete();
    end else begin
      bit ld;
      ld = 0;
      if (tx_sub && m_sube && m_te)      begin ld = 1; {m_subf, m_tnd, m_rnd} = 3'b110; end
      else if (rx_sub && m_sube && m_re) begin ld = 1; {m_subf, m_tnd, m_rnd} = 3'b101; end
      else if (tx_end && m_te)           begin ld = 1; {m_subf, m_tnd, m_rnd} = 3'b010; end
      else if (rx_end && m_re)           begin ld = 1; {m_subf, m_tnd, m_rnd} = 3'b001; end
      else if (stat_rd)                  {m_subf, m_tnd, m_rnd} = 3'b000;
      if (ld || (ferr && m_re)) m_pend = 1; else if (stat_rd) m_pend = 0;
      if (ferr) m_fer = 1; else if (stat_rd) m_fer = 0;
      if (crc)  m_cer = 1; else if (stat_rd) m_cer = 0;
      if (tx_sub || rx_sub || tx_end || rx_end) m_adir = ant;
      if (rx_end) begin m_id = m_seen || uid; m_seen = 0; end
      else if (uid) m_seen = 1;
      lk_q.push_back(lock); rlk_q.push_back(rlock);
      if (lk_q.size() == LS) begin m_lk = lk_q.pop_front(); m_rlk = rlk_q.pop_front(); end
      if (ctrl_we) {m_sube, m_te, m_re, m_ms, m_tn} = ctrl_wdata[4:0];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    chk(status[7:6] == {m_lk, m_rlk}, "R12 lock bits", status[7:6], {m_lk, m_rlk});
    chk(status[5] == m_adir, "R11 adir", status[5], m_adir);
    chk({status[4], status[1:0]} == {m_subf, m_tnd, m_rnd}, "R2 event code",
        {status[4], status[1:0]}, {m_subf, m_tnd, m_rnd});
    chk(status[3] == m_fer, "R6 fer", status[3], m_fer);
    chk(status[2] == m_cer && cer_n == !m_cer, "R7 cer", {status[2], cer_n}, {m_cer, !m_cer});
    chk(intr_n == !m_pend, "R5 intr", intr_n, !m_pend);
    chk(iddet_n == !m_id, "R10 id_det", iddet_n, !m_id);
    chk({master, tmode} == {m_ms, m_tn}, "R13 mode bits", {master, tmode}, {m_ms, m_tn});
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare_model();
    {ctrl_we, stat_rd, tx_sub, rx_sub, tx_end, rx_end, crc, ferr, uid} = 0;
  endtask

  task automatic wr(input logic [7:0] v);
    ctrl_we = 1; ctrl_wdata = v; cyc();
  endtask

  task automatic rd();
    stat_rd = 1; cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(status == 8'h00 && intr_n && cer_n && iddet_n && !master && !tmode, "R1 reset",
        {status, intr_n, cer_n, iddet_n, master, tmode}, 13'h01C);
    rst_n = 1;
    @(negedge clk);
    wr(8'h1C);
    tx_sub = 1; cyc();
    chk((status & 8'h1F) == 8'h12 && !intr_n, "R2 tx subframe", status, 8'h12);
    rd();
    chk((status & 8'h1F) == 8'h00 && intr_n, "R8 read clears", status, 8'h00);
    rx_sub = 1; cyc();
    chk((status & 8'h1F) == 8'h11 && !intr_n, "R3 rx subframe", status, 8'h11);
    rd();
    tx_end = 1; cyc();
    chk((status & 8'h1F) == 8'h02 && !intr_n, "R4 tx end", status, 8'h02);
    rd();
    rx_end = 1; cyc();
    chk((status & 8'h1F) == 8'h01 && !intr_n, "R4 rx end", status, 8'h01);
    rd();
    wr(8'h0C);
    tx_sub = 1; cyc();
    chk((status & 8'h1F) == 8'h00 && intr_n, "R5 no SUBE", status, 8'h00);
    wr(8'h14);
    tx_sub = 1; cyc();
    chk((status & 8'h1F) == 8'h00 && intr_n, "R5 no TE sub", status, 8'h00);
    tx_end = 1; cyc();
    chk((status & 8'h1F) == 8'h00 && intr_n, "R5 no TE end", status, 8'h00);
    wr(8'h00);
    ferr = 1; cyc();
    chk((status & 8'h1F) == 8'h08 && intr_n, "R6 fer masked", {status, intr_n}, 9'h011);
    rd();
    wr(8'h04);
    ferr = 1; cyc();
    chk(status[3] && !intr_n, "R6 fer irq", {status[3], intr_n}, 2'b10);
    rd();
    crc = 1; cyc();
    chk(status[2] && !cer_n, "R7 crc", {status[2], cer_n}, 2'b10);
    rd();
    chk(!status[2] && cer_n, "R7 crc cleared", {status[2], cer_n}, 2'b01);
    wr(8'h1C);
    rx_sub = 1; stat_rd = 1; cyc();
    chk((status & 8'h1F) == 8'h11 && !intr_n, "R9 event beats read", status, 8'h11);
    rd();
    uid = 1; cyc();
    cyc();
    rx_end = 1; cyc();
    chk(!iddet_n, "R10 id detected", iddet_n, 0);
    rd();
    rx_end = 1; cyc();
    chk(iddet_n, "R10 no id", iddet_n, 1);
    rd();
    ant = 1; wr(8'h00);
    tx_sub = 1; cyc();
    chk(status[5], "R11 adir sample", status[5], 1);
    ant = 0; rd();
    chk(status[5], "R8 read keeps adir", status[5], 1);
    lock = 1; rlock = 1; cyc();
    chk(status[7:6] == 2'b11, "R12 lock follow", status[7:6], 2'b11);
    rd();
    chk(status[7:6] == 2'b11, "R8 read keeps lock", status[7:6], 2'b11);
    wr(8'hE3);
    chk(master && tmode, "R13 mode bits", {master, tmode}, 2'b11);
    tx_sub = 1; cyc();
    chk(intr_n && (status & 8'h1F) == 0, "R13 upper bits ignored", status, 0);

    // randomized phase, compared to the model every cycle
    for (int i = 0; i < 4000; i++) begin
      int e;
      e = $urandom_range(0, 11);
      tx_sub = (e == 0); rx_sub = (e == 1); tx_end = (e == 2); rx_end = (e == 3);
      crc  = ($urandom_range(0, 15) == 0);
      ferr = ($urandom_range(0, 15) == 0);
      uid  = ($urandom_range(0, 7) == 0);
      stat_rd = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 19) == 0) begin ctrl_we = 1; ctrl_wdata = 8'($urandom); end
      if ($urandom_range(0, 9) == 0) ant = ~ant;
      if ($urandom_range(0, 29) == 0) lock = ~lock;
      if ($urandom_range(0, 29) == 0) rlock = ~rlock;
      cyc();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule